// File: doc/BRIEF.md
# Sticky Interrupt Set/Clear Register Bank

This block collects the interrupt causes of a serial controller into one interrupt line. Thirteen event pulses arrive from the datapath, each one clock cycle wide. Every pulse latches a sticky pending bit. Software controls which pending bits reach the interrupt line through a mask. The mask is never written directly. Instead, one address sets mask bits and a second address clears them, so no read-modify-write is needed.

The mask can be read back at its own address, where writes are ignored. Pending bits are read at the status address and cleared by writing ones to it. The interrupt line is a registered OR of the pending bits that are also masked in.

Bit positions are fixed, from bit 0 upward:

| Bit | Source |
|-----|--------|
| 0 | receive trigger level |
| 1 | receive empty |
| 2 | receive full |
| 3 | transmit empty |
| 4 | transmit full |
| 5 | receive overrun |
| 6 | framing error |
| 7 | parity error |
| 8 | receive timeout |
| 9 | modem line change |
| 10 | transmit trigger level |
| 11 | transmit almost full |
| 12 | transmit overrun |

Top module: `irq_bank`

## Requirements
- R1: After reset, the mask reads 0, the status reads 0 and `irq` is 0.
- R2: A write to byte offset 0x08 (set-mask) sets each mask bit whose data bit is one. Mask bits whose data bit is zero keep their value.
- R3: A write to byte offset 0x0C (clear-mask) clears each mask bit whose data bit is one. Mask bits whose data bit is zero keep their value.
- R4: A pulse on `evt[i]` sets status bit i in the next cycle, whatever the mask holds. The bit then stays set until it is cleared.
- R5: A write to byte offset 0x14 (status) clears each status bit whose data bit is one. Status bits whose data bit is zero keep their value.
- R6: If an event and a status clear hit the same bit in the same cycle, the bit is set after that cycle.
- R7: `irq` is registered. It equals the OR of (status AND mask) as held one cycle earlier, so it changes one cycle after the status or mask changes.
- R8: Reading offset 0x10 returns the mask in bits [12:0]. Reading offset 0x14 returns the status in bits [12:0]. Bits [31:13] of both reads are zero, and reads of 0x08 and 0x0C return zero.
- R9: Writes to the mask read-back offset 0x10 change nothing. Write-data bits [31:13] have no effect at any offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| evt | input | 13 | Single-cycle event pulses, one per source |
| irq | output | 1 | Registered interrupt line |

## Verification
Two functions can act on one status bit in the same cycle: a datapath event setting it, and a software write-one-to-clear. The bench provokes this by pulsing the event in the same cycle as the clearing write. It aims the write at the colliding bit and at a second set bit that has no event. The judgement is the status read on the next cycle: the colliding bit must still be set and the other bit must be clear. It is also checked that `irq` stays asserted while that bit is masked in.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
   // fixed source positions
   parameter int SRC_RX_TRIG  = 0;
   parameter int SRC_RX_EMPTY = 1;
   parameter int SRC_RX_FULL  = 2;
   parameter int SRC_TX_EMPTY = 3;
   parameter int SRC_TX_FULL  = 4;
   parameter int SRC_RX_OVR   = 5;
   parameter int SRC_FRAME    = 6;
   parameter int SRC_PARITY   = 7;
   parameter int SRC_RX_TOUT  = 8;
   parameter int SRC_MODEM    = 9;
   parameter int SRC_TX_TRIG  = 10;
   parameter int SRC_TX_AFULL = 11;
   parameter int SRC_TX_OVR   = 12;
   parameter int SRC_COUNT    = 13;

   typedef enum logic [1:0] {
      SEL_ZERO = 2'd0,
      SEL_MASK = 2'd1,
      SEL_STAT = 2'd2
   } rd_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
   import irq_bank_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NUM_SRC = 13,
   parameter logic [ADDR_W-1:0] OFS_SET  = 'h08,
   parameter logic [ADDR_W-1:0] OFS_CLR  = 'h0C,
   parameter logic [ADDR_W-1:0] OFS_MASK = 'h10,
   parameter logic [ADDR_W-1:0] OFS_STAT = 'h14
) (
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [NUM_SRC-1:0] wr_bits,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [NUM_SRC-1:0] mask_set,
   output logic [NUM_SRC-1:0] mask_clr,
   output logic [NUM_SRC-1:0] stat_clr,
   output rd_sel_e            rd_sel
);
   always_comb begin
      mask_set = '0;
      mask_clr = '0;
      stat_clr = '0;
      if (wr_en) begin
         if (wr_addr == OFS_SET) mask_set = wr_bits;
         if (wr_addr == OFS_CLR) mask_clr = wr_bits;
         if (wr_addr == OFS_STAT) stat_clr = wr_bits;
      end
   end

   always_comb begin
      if (rd_addr == OFS_MASK)      rd_sel = SEL_MASK;
      else if (rd_addr == OFS_STAT) rd_sel = SEL_STAT;
      else                          rd_sel = SEL_ZERO;
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int NUM_SRC = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_bits,
   input  logic [NUM_SRC-1:0] clr_bits,
   output logic [NUM_SRC-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= (mask_q | set_bits) & ~clr_bits;
   end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int NUM_SRC = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic [NUM_SRC-1:0] clr_bits,
   output logic [NUM_SRC-1:0] stat_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stat_q[i] <= 1'b0;
         else if (evt[i]) stat_q[i] <= 1'b1;
         else if (clr_bits[i]) stat_q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
   import irq_bank_pkg::*;
#(
   parameter int NUM_SRC = 13,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter bit REG_IRQ = 1'b1,
   parameter logic [ADDR_W-1:0] OFS_SET  = 'h08,
   parameter logic [ADDR_W-1:0] OFS_CLR  = 'h0C,
   parameter logic [ADDR_W-1:0] OFS_MASK = 'h10,
   parameter logic [ADDR_W-1:0] OFS_STAT = 'h14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_SRC-1:0] evt,
   output logic               irq
);
   localparam int PAD_W = DATA_W - NUM_SRC;

   if (NUM_SRC > DATA_W) begin : g_chk_width
      $error("irq_bank: NUM_SRC exceeds DATA_W");
   end
   if (OFS_SET == OFS_CLR || OFS_SET == OFS_STAT || OFS_CLR == OFS_STAT
       || OFS_MASK == OFS_STAT || OFS_MASK == OFS_SET || OFS_MASK == OFS_CLR) begin : g_chk_ofs
      $error("irq_bank: register offsets collide");
   end

   logic [NUM_SRC-1:0] mask_set, mask_clr, stat_clr;
   logic [NUM_SRC-1:0] mask_q, stat_q;
   rd_sel_e            rd_sel;
   logic               irq_raw;

   if (PAD_W > 0) begin : g_unused_hi
      logic unused_wr_hi;
      assign unused_wr_hi = ^wr_data[DATA_W-1:NUM_SRC];
   end

   irq_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC),
      .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR),
      .OFS_MASK(OFS_MASK), .OFS_STAT(OFS_STAT)
   ) u_dec (
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_bits  (wr_data[NUM_SRC-1:0]),
      .rd_addr  (rd_addr),
      .mask_set (mask_set),
      .mask_clr (mask_clr),
      .stat_clr (stat_clr),
      .rd_sel   (rd_sel)
   );

   irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (mask_set),
      .clr_bits (mask_clr),
      .mask_q   (mask_q)
   );

   irq_status_reg #(.NUM_SRC(NUM_SRC)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .clr_bits (stat_clr),
      .stat_q   (stat_q)
   );

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_MASK: rd_data[NUM_SRC-1:0] = mask_q;
         SEL_STAT: rd_data[NUM_SRC-1:0] = stat_q;
         default:  rd_data = '0;
      endcase
   end

   assign irq_raw = |(stat_q & mask_q);

   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_raw;
      end
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
   parameter int NUM_SRC = 13,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter bit REG_IRQ = 1'b1,
   parameter logic [ADDR_W-1:0] OFS_SET  = 'h08,
   parameter logic [ADDR_W-1:0] OFS_CLR  = 'h0C,
   parameter logic [ADDR_W-1:0] OFS_STAT = 'h14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic [NUM_SRC-1:0] evt,
   input logic [NUM_SRC-1:0] mask_q,
   input logic [NUM_SRC-1:0] stat_q,
   input logic               irq
);
   logic [NUM_SRC-1:0] wbits;
   assign wbits = wr_data[NUM_SRC-1:0];

   // R2
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_SET) |=> ((mask_q & $past(wbits)) == $past(wbits)));

   // R3
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_CLR) |=> ((mask_q & $past(wbits)) == '0));

   // R4
   evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

   // R5
   stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_STAT) |=> ((stat_q & $past(wbits & ~evt)) == '0));

   // R6
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_STAT && |(wbits & evt))
      |=> ((stat_q & $past(wbits & evt)) == $past(wbits & evt)));

   if (REG_IRQ) begin : g_irq_chk
      // R7
      irq_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(|(stat_q & mask_q))));
   end
endmodule

bind irq_bank irq_bank_chk #(
   .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_IRQ(REG_IRQ),
   .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR), .OFS_STAT(OFS_STAT)
) u_irq_bank_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .evt     (evt),
   .mask_q  (mask_q),
   .stat_q  (stat_q),
   .irq     (irq)
);

// File: tb/tb_irq_bank.sv
`timescale 1ns/1ps
module tb_irq_bank;
   localparam int NS = 13;
   localparam logic [7:0] A_SET = 8'h08, A_CLR = 8'h0C, A_MASK = 8'h10, A_STAT = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [NS-1:0] evt = '0;
   logic        irq;

   always #2 clk = ~clk;

   irq_bank dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .evt(evt), .irq(irq)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       req;
   } sb_item_t;

   sb_item_t sb_q[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state derived from the requirements
   logic [NS-1:0] m_mask = '0;
   logic [NS-1:0] m_stat = '0;

   // monitor: pops expectations and compares shortly after they are posted
   initial begin
      forever begin
         wait (sb_q.size() > 0);
         #0.3;
         begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {31'd0, irq} : rd_data;
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
            end
         end
      end
   end

   // one clock cycle of stimulus, driven after a falling edge
   task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input logic [NS-1:0] e);
      wr_en = we; wr_addr = a; wr_data = d; evt = e;
      @(posedge clk);
      if (we && a == A_SET) m_mask = m_mask | d[NS-1:0];
      if (we && a == A_CLR) m_mask = m_mask & ~d[NS-1:0];
      if (we && a == A_STAT) m_stat = m_stat & ~d[NS-1:0];
      m_stat = m_stat | e;
      @(negedge clk);
      wr_en = 1'b0; evt = '0;
   endtask

   task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
      sb_item_t it;
      rd_addr = a;
      it.is_irq = 1'b0; it.exp = exp; it.req = req;
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic chk_irq(input bit exp, input string req);
      sb_item_t it;
      it.is_irq = 1'b1; it.exp = {31'd0, exp}; it.req = req;
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   initial begin
      #20000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_rd(A_MASK, 32'h0, "R1");
      chk_rd(A_STAT, 32'h0, "R1");
      chk_irq(1'b0, "R1");

      // R2 set-mask, zeros leave bits alone
      step(1, A_SET, 32'h0000_0005, '0);
      chk_rd(A_MASK, 32'h0000_0005, "R2");
      step(1, A_SET, 32'h0000_0002, '0);
      chk_rd(A_MASK, 32'h0000_0007, "R2");
      // R9 / R8 upper data bits ignored and read as zero
      step(1, A_SET, 32'hFFFF_FFFF, '0);
      chk_rd(A_MASK, 32'h0000_1FFF, "R8");

      // R3 clear-mask
      step(1, A_CLR, 32'h0000_0003, '0);
      chk_rd(A_MASK, 32'h0000_1FFC, "R3");

      // R9 write to mask read-back offset has no effect
      step(1, A_MASK, 32'h0000_0000, '0);
      chk_rd(A_MASK, 32'h0000_1FFC, "R9");
      // R8 set/clear offsets read zero
      chk_rd(A_SET, 32'h0, "R8");
      chk_rd(A_CLR, 32'h0, "R8");

      // R4 events latch while masked out
      step(1, A_CLR, 32'h0000_1FFF, '0);
      chk_rd(A_MASK, 32'h0, "R3");
      step(0, 8'h00, 32'h0, 13'h1001);
      chk_rd(A_STAT, 32'h0000_1001, "R4");
      chk_irq(1'b0, "R7");
      chk_rd(A_STAT, 32'h0000_1001, "R4");

      // R7 irq follows mask one cycle late
      step(1, A_SET, 32'h0000_0001, '0);
      chk_irq(1'b0, "R7");
      chk_irq(1'b1, "R7");

      // R5 clear bit 0 only, bit 12 stays
      step(1, A_STAT, 32'h0000_0001, '0);
      chk_irq(1'b1, "R7");
      chk_irq(1'b0, "R7");
      chk_rd(A_STAT, {19'd0, m_stat}, "R5");
      chk_rd(A_STAT, 32'h0000_1000, "R5");

      // R6 event and clear collide on bit 3; bit 12 clears
      step(1, A_SET, 32'h0000_0008, '0);
      step(1, A_STAT, 32'h0000_1008, 13'h0008);
      chk_rd(A_STAT, 32'h0000_0008, "R6");
      chk_irq(1'b1, "R6");

      // R3 clearing mask bit drops irq with status still pending
      step(1, A_CLR, 32'h0000_0008, '0);
      chk_irq(1'b1, "R7");
      chk_irq(1'b0, "R3");
      chk_rd(A_STAT, 32'h0000_0008, "R4");

      // R4 / R5 all sources at once, then clear all
      step(0, 8'h00, 32'h0, 13'h1FFF);
      chk_rd(A_STAT, 32'h0000_1FFF, "R4");
      step(1, A_STAT, 32'hFFFF_FFFF, '0);
      chk_rd(A_STAT, 32'h0, "R5");
      chk_rd(A_MASK, {19'd0, m_mask}, "R2");
      chk_irq(1'b0, "R7");

      wait (sb_q.size() == 0);
      #1;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule